// File: doc/BRIEF.md
# Addend-Tuned Precision Time Counter

This block keeps the system time of a precision time protocol clock as a 64-bit count of 32 ns units. It does not add a fixed step on each reference clock cycle. Instead, a 32-bit fractional accumulator adds a programmable addend every cycle, and each overflow of that accumulator advances the time count by one. Software converts the count to nanoseconds by shifting it left five bits. It trims the clock rate by moving the addend up or down from its nominal value 0xA0000000. The step for an offset of p parts per billion is nominal × p / 1e9, and |p| may be at most 50,000,000.

A plain 32-bit register bus with word addresses gives access to four registers: a control word, the addend and the two halves of the time count. A read of the low time word freezes the high word in a shadow register, so a read of the low half followed by the high half gives one coherent 64-bit value. A write of the low half only stages it. The following write of the high half loads all 64 bits at once and restarts the fractional phase. Bit 0 of the control word holds all time state in its initial condition for as long as it is set.

Top module: `ptc_tick_clock`

## Requirements
- R1: Register word addresses are 0 control, 1 addend, 2 time low, 3 time high. After the synchronous active-low reset, the control word reads 0, the addend reads 0xA0000000, the time count is 0 and the high-word shadow reads 0.
- R2: On every clock cycle the addend is added modulo 2^32 to a 32-bit accumulator, and the count increases by one on each overflow. k cycles after the accumulator was cleared, the count equals its starting value plus floor(k × addend / 2^32).
- R3: With addend 0x80000000 the count increments exactly once every two cycles and alternates between stepping and holding.
- R4: At the nominal addend 0xA0000000 the count advances 5 units per 8 cycles (0.625 per cycle).
- R5: A read strobe on the time-low word returns the current low half and captures the current high half into a shadow. The time-high word returns that shadow, even if the count's high half has changed since.
- R6: A write to the time-low word only stages the value. The running count is unaffected.
- R7: A write to the time-high word loads {written value, staged low} into the count in the same cycle and clears the accumulator. Counting then resumes per R2.
- R8: While control bit 0 is 1, the count, accumulator, staged low word and shadow are held at 0. The addend keeps its value and stays writable. After the bit is cleared, counting restarts from 0.
- R9: The control word reads back bit 0 as written. Bits 31..1 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one accumulation per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_rd | input | 1 | Read strobe; on the time-low word it captures the shadow |
| bus_addr | input | 2 | Word address (0 control, 1 addend, 2 time low, 3 time high) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |

## Verification
The bench builds the block with its default 32-bit word and nominal addend 0xA0000000. It then reprograms the addend, with control bit 0 held, to 0x80000000, 0, 0xFFFFFFFF and 0x12345678. These values cover an exact half rate, a frozen clock, a step on nearly every cycle and an irregular fractional pattern, and the bench predicts each one from floor(k × addend / 2^32). A load of 0x5_FFFFFFFF at half rate pushes a carry into the high word between a low read and the matching high read, which exposes the shadow's coherence.

// File: rtl/ptc_pkg.sv
// Package ptc_pkg
// Shared register map of the addend-tuned time counter.
// Assumes a word-addressed bus with four registers.
package ptc_pkg;
    localparam int unsigned REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL    = 2'd0,
        REG_ADDEND  = 2'd1,
        REG_TIME_LO = 2'd2,
        REG_TIME_HI = 2'd3
    } ptc_reg_e;

    localparam int unsigned CTRL_HOLD_BIT = 0;
endpackage

// File: rtl/ptc_frac_accum.sv
// Module ptc_frac_accum
// Fractional phase accumulator: adds the addend every cycle and reports
// the carry out of the addition in the same cycle.
// Assumes clear has priority and that the carry is ignored by the
// consumer in a cycle where clear is asserted.
module ptc_frac_accum #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [ACC_W-1:0] addend,
    output logic             carry
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    // Widened sum so that the overflow is visible as its top bit.
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, addend};
        carry = sum[ACC_W];
    end

    // Phase register: restarts at zero on reset or clear, otherwise wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/ptc_tick_counter.sv
// Module ptc_tick_counter
// Time count in 32 ns units with clear, parallel load and single-step.
// Assumes the priority clear > load > increment; it wraps at 2^CNT_W.
module ptc_tick_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    // Count register: reset/clear, else load, else step on a carry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (inc) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count = count_q;
endmodule

// File: rtl/ptc_regfile.sv
// Module ptc_regfile
// Bus-facing registers: control hold bit, addend, staged low time word
// and high-word shadow, plus the read multiplexer.
// Assumes at most one of bus_wr / bus_rd acts per cycle on one address;
// read data is combinational from the current address.
module ptc_regfile
    import ptc_pkg::*;
#(
    parameter int unsigned              DATA_W         = 32,
    parameter logic [DATA_W-1:0]        NOMINAL_ADDEND = 32'hA000_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [2*DATA_W-1:0]   count,
    output logic [DATA_W-1:0]     addend,
    output logic                  hold,
    output logic                  load,
    output logic [2*DATA_W-1:0]   load_val,
    output logic [DATA_W-1:0]     bus_rdata
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    logic              hold_q;
    logic [DATA_W-1:0] addend_q;
    logic [DATA_W-1:0] staged_lo_q;
    logic [DATA_W-1:0] shadow_hi_q;
    logic              wr_ctrl, wr_addend, wr_lo, wr_hi, rd_lo;

    // Address decode of the bus strobes.
    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
        wr_addend = bus_wr && (bus_addr == REG_ADDEND);
        wr_lo     = bus_wr && (bus_addr == REG_TIME_LO);
        wr_hi     = bus_wr && (bus_addr == REG_TIME_HI);
        rd_lo     = bus_rd && (bus_addr == REG_TIME_LO);
    end

    // Control hold bit: set and cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (wr_ctrl) begin
            hold_q <= bus_wdata[CTRL_HOLD_BIT];
        end
    end

    // Addend: nominal after reset, writable at any time including hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addend_q <= NOMINAL_ADDEND;
        end else if (wr_addend) begin
            addend_q <= bus_wdata;
        end
    end

    // Staged low word: waits for the high-word write that commits it.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_q) begin
            staged_lo_q <= '0;
        end else if (wr_lo) begin
            staged_lo_q <= bus_wdata;
        end
    end

    // High shadow: frozen at each low-word read for a coherent pair.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_q) begin
            shadow_hi_q <= '0;
        end else if (rd_lo) begin
            shadow_hi_q <= count[CNT_W-1:DATA_W];
        end
    end

    // Load request towards the counter; hold takes precedence.
    always_comb begin
        load     = wr_hi && !hold_q;
        load_val = {bus_wdata, staged_lo_q};
    end

    // Read multiplexer.
    always_comb begin
        unique case (bus_addr)
            REG_CTRL:    bus_rdata = {{(DATA_W-1){1'b0}}, hold_q};
            REG_ADDEND:  bus_rdata = addend_q;
            REG_TIME_LO: bus_rdata = count[DATA_W-1:0];
            default:     bus_rdata = shadow_hi_q;
        endcase
    end

    assign addend = addend_q;
    assign hold   = hold_q;
endmodule

// File: rtl/ptc_tick_clock.sv
// Module ptc_tick_clock (top)
// Addend-tuned precision time counter: a fractional accumulator paces a
// 64-bit count of 32 ns units; a word bus reads and loads it coherently.
// Assumes one reference clock and a synchronous active-low reset.
module ptc_tick_clock
    import ptc_pkg::*;
#(
    parameter int unsigned       DATA_W         = 32,
    parameter logic [DATA_W-1:0] NOMINAL_ADDEND = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    logic [DATA_W-1:0] addend_w;
    logic              hold_w;
    logic              load_w;
    logic [CNT_W-1:0]  load_val_w;
    logic              carry_w;
    logic [CNT_W-1:0]  count_w;
    logic              acc_clear_w;

    // The phase restarts on hold and on every full-time load.
    assign acc_clear_w = hold_w || load_w;

    ptc_regfile #(
        .DATA_W         (DATA_W),
        .NOMINAL_ADDEND (NOMINAL_ADDEND)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (count_w),
        .addend    (addend_w),
        .hold      (hold_w),
        .load      (load_w),
        .load_val  (load_val_w),
        .bus_rdata (bus_rdata)
    );

    ptc_frac_accum #(
        .ACC_W (DATA_W)
    ) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (acc_clear_w),
        .addend (addend_w),
        .carry  (carry_w)
    );

    ptc_tick_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hold_w),
        .load     (load_w),
        .load_val (load_val_w),
        .inc      (carry_w),
        .count    (count_w)
    );
endmodule

// File: rtl/ptc_tick_clock_chk.sv
// Module ptc_tick_clock_chk
// Property checker bound into ptc_tick_clock; observes bus ports and the
// nets that join the register file, accumulator and counter.
module ptc_tick_clock_chk
    import ptc_pkg::*;
#(
    parameter int unsigned       DATA_W         = 32,
    parameter logic [DATA_W-1:0] NOMINAL_ADDEND = 32'hA000_0000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [REG_AW-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [DATA_W-1:0]     addend,
    input logic                  hold,
    input logic                  load,
    input logic                  carry,
    input logic [2*DATA_W-1:0]   count
);
    localparam int unsigned CNT_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] HALF_ADDEND = {1'b1, {(DATA_W-1){1'b0}}};

    // R1: state right after reset leaves.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (addend == NOMINAL_ADDEND && count == '0 && !hold));

    // R2: count steps exactly by the accumulator carry when not loaded or held.
    assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !load) |=> count == $past(count) + CNT_W'($past(carry)));

    // R3: at half rate the carry alternates cycle by cycle.
    assert_half_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addend == HALF_ADDEND && $past(addend) == HALF_ADDEND
         && !hold && !load && !$past(hold) && !$past(load))
        |-> carry != $past(carry));

    // R5: high word read after a low read returns the high half at that read.
    assert_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_TIME_LO && !hold) ##1 (bus_addr == REG_TIME_HI)
        |-> bus_rdata == $past(count[CNT_W-1:DATA_W]));

    // R6: a low-word write leaves the running count on its own course.
    assert_stage_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_TIME_LO && !hold)
        |=> count == $past(count) + CNT_W'($past(carry)));

    // R7: a high-word write lands in the count's high half next cycle.
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_TIME_HI && !hold)
        |=> count[CNT_W-1:DATA_W] == $past(bus_wdata));

    // R8: hold keeps the count at zero.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> count == '0);

    // R9: control readback shows only the hold bit.
    assert_ctrl_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_CTRL) |-> (bus_rdata[DATA_W-1:1] == '0 && bus_rdata[0] == hold));
endmodule

bind ptc_tick_clock ptc_tick_clock_chk #(
    .DATA_W         (DATA_W),
    .NOMINAL_ADDEND (NOMINAL_ADDEND)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .addend    (addend_w),
    .hold      (hold_w),
    .load      (load_w),
    .carry     (carry_w),
    .count     (count_w)
);

// File: tb/sim_ptc_tick_clock.sv
// Bench for ptc_tick_clock: the driver computes expected words from the
// rate formula and queues them with the sampled data; a monitor pops
// and compares them.
module sim_ptc_tick_clock;
    import ptc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    int unsigned ecount = 0;
    bit          done   = 1'b0;

    // Reference model state: count = base_val + floor(k*addend/2^32).
    logic [63:0] base_val = 64'd0;
    int unsigned base_e   = 0;
    logic [31:0] addend_m = 32'hA000_0000;
    logic [31:0] staged_m = 32'd0;

    logic [31:0] exp_q[$];
    logic [31:0] got_q[$];
    string       tag_q[$];

    ptc_tick_clock u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) ecount <= ecount + 1;

    function automatic logic [63:0] model_now();
        logic [63:0] k;
        k = 64'(ecount - base_e);
        return base_val + ((k * {32'd0, addend_m}) >> 32);
    endfunction

    task automatic push(input logic [31:0] e, input logic [31:0] g, input string t);
        exp_q.push_back(e);
        got_q.push_back(g);
        tag_q.push_back(t);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_check(input logic [1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 push(e, bus_rdata, t);
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic read_lo_model(input string t);
        logic [63:0] m;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = REG_TIME_LO;
        #1 m = model_now();
        push(m[31:0], bus_rdata, t);
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic read_time(input string t);
        logic [63:0] snap;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = REG_TIME_LO;
        #1 snap = model_now();
        push(snap[31:0], bus_rdata, {t, " low"});
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = REG_TIME_HI;
        #1 push(snap[63:32], bus_rdata, {t, " high"});
    endtask

    task automatic restart_with(input logic [31:0] a);
        bus_write(REG_CTRL, 32'd1);
        bus_write(REG_ADDEND, a);
        bus_write(REG_CTRL, 32'hFFFF_FFFE);
        addend_m = a; base_val = 64'd0; base_e = ecount; staged_m = 32'd0;
    endtask

    task automatic load_time(input logic [31:0] hi, input logic [31:0] lo);
        bus_write(REG_TIME_LO, lo);
        staged_m = lo;
        bus_write(REG_TIME_HI, hi);
        base_val = {hi, staged_m}; base_e = ecount;
    endtask

    // Monitor: compares queued expected and observed words.
    initial begin
        forever begin
            @(posedge clk);
            while (exp_q.size() > 0) begin
                logic [31:0] e, g;
                string t;
                e = exp_q.pop_front(); g = got_q.pop_front(); t = tag_q.pop_front();
                checks++;
                if (e !== g) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, g, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Driver.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        base_e = ecount;

        // R1 reset values
        read_check(REG_CTRL, 32'd0, "R1 control after reset");
        read_check(REG_ADDEND, 32'hA000_0000, "R1 addend after reset");
        read_check(REG_TIME_HI, 32'd0, "R1 shadow after reset");
        read_lo_model("R1 time low just after reset");

        // R4 nominal rate
        repeat (100) @(negedge clk);
        read_time("R4 nominal rate");

        // R8 hold and R9 control readback
        bus_write(REG_CTRL, 32'd1);
        read_check(REG_CTRL, 32'd1, "R9 control bit set");
        read_check(REG_TIME_LO, 32'd0, "R8 low held at zero");
        read_check(REG_TIME_HI, 32'd0, "R8 shadow held at zero");
        bus_write(REG_TIME_LO, 32'h1234_5678);
        bus_write(REG_TIME_HI, 32'h0000_0099);
        read_check(REG_TIME_LO, 32'd0, "R8 writes ignored while held");
        bus_write(REG_ADDEND, 32'h8000_0000);
        read_check(REG_ADDEND, 32'h8000_0000, "R8 addend writable while held");
        bus_write(REG_CTRL, 32'hFFFF_FFFE);
        addend_m = 32'h8000_0000; base_val = 64'd0; base_e = ecount;
        read_check(REG_CTRL, 32'd0, "R9 upper bits read zero");

        // R3 half rate: consecutive low reads alternate
        for (int i = 0; i < 6; i++) read_lo_model("R3 half rate step");
        read_time("R8 restart from zero at half rate");

        // R6 staging, R5 shadow coherence, R7 load
        repeat (7) @(negedge clk);
        bus_write(REG_TIME_LO, 32'hFFFF_FFFF);
        staged_m = 32'hFFFF_FFFF;
        read_lo_model("R6 low write only staged");
        bus_write(REG_TIME_HI, 32'h0000_0005);
        base_val = {32'h0000_0005, staged_m}; base_e = ecount;
        read_check(REG_TIME_LO, 32'hFFFF_FFFF, "R7 loaded low word");
        read_check(REG_TIME_HI, 32'h0000_0005, "R5 shadow keeps pre-carry high");
        read_time("R7 carry into high after load");

        // R2 various addends
        restart_with(32'h0000_0000);
        repeat (50) @(negedge clk);
        read_time("R2 zero addend freezes time");
        restart_with(32'hFFFF_FFFF);
        repeat (40) @(negedge clk);
        read_time("R2 all-ones addend");
        restart_with(32'h1234_5678);
        repeat (300) @(negedge clk);
        read_time("R2 irregular addend");
        load_time(32'h0123_4567, 32'h89AB_CDEF);
        repeat (25) @(negedge clk);
        read_time("R7 arbitrary load then count");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule